// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This controller sits in a synchronous system clock domain and drives an external asynchronous static RAM of 131072 words by 32 bits. The RAM is organised as four byte-wide lanes. Each lane has its own active-low chip select and its own active-low write enable. All lanes share one active-low output enable and one 17-bit address bus. The data bus is presented as separate output, output-enable and input vectors, and the pad ring combines them into the bidirectional pins.

Requests arrive on a valid/ready port as single-cycle commands. Each command carries an address, a write flag, write data and a four-bit byte-enable mask. A write is shaped as a setup cycle, then a write-enable-controlled strobe lasting a parameterised number of cycles, then a hold cycle. A read holds the output enable and the selected chip selects low for a parameterised access window. It then returns all 32 bits with a one-cycle valid pulse, and lanes that were not selected read as zero. A read that follows a write waits through turnaround cycles first. A retention request takes the RAM to full deselect. When the request is released, a long recovery count must finish before the next access. All timing values are cycle counts and must each be at least 1.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, `req_ready` is 1, all chip selects and write enables are high, `sram_oe_n` is high, `sram_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A write accepted at a clock edge shows the following after that edge. First, one setup cycle: chip selects of the enabled lanes low, write enables high, output enable high, data driven. Next, exactly WE_CYCLES cycles with those lanes' write enables low. Last, one hold cycle with write enables high while chip selects stay low and data is still driven. Address and data stay stable across the strobe.
- R3: Bit i of `req_be` controls lane i, which is data bits [8i+7:8i]. On a write, a lane whose bit is 0 keeps its chip select and write enable high, and its stored byte is unchanged.
- R4: A read holds the enabled lanes' chip selects low, the output enable low and all write enables high for exactly RD_CYCLES cycles. The data is captured at the end of the last of those cycles. `rsp_valid` is high for exactly one cycle, the one that follows, with the data on `rsp_rdata`.
- R5: A read with a partial mask keeps the chip selects of unselected lanes high, and those bytes of `rsp_rdata` read as zero.
- R6: A read accepted after a write is preceded by TURN_CYCLES cycles in which all chip selects and the output enable are high and the data bus is not driven. A read that follows a read starts its access in the first cycle after acceptance.
- R7: `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R8: `req_ready` is 0 from the cycle after acceptance until the access finishes. While it is 1, the RAM bus is quiet: every chip select and the output enable are high, and the data bus is not driven.
- R9: A retention request is taken only from idle. If a request is valid in the same cycle, the access goes first. During retention all chip selects and write enables stay high, `req_ready` is 0 and offered requests have no effect.
- R10: After `ret_req` falls, `req_ready` stays 0 for exactly REC_CYCLES cycles with all chip selects high. Then it returns to 1.
- R11: A lane's write enable is low only while that lane's chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 4 | Byte-lane enable mask |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| ret_req | input | 1 | Hold high to keep the RAM in retention |
| sram_addr | output | 17 | RAM address bus |
| sram_cs_n | output | 4 | Per-lane active-low chip selects |
| sram_we_n | output | 4 | Per-lane active-low write enables |
| sram_oe_n | output | 1 | Shared active-low output enable |
| sram_dq_out | output | 32 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 32 | Data received from the RAM |

## Verification
A sequencer stuck in the wrong state or a miscounted cycle counter shows up within one cycle as a strobe that is too short or too long, a missing setup or hold cycle, or a `rsp_valid` pulse that is early or late. A lost write-history flag shows up on the first read after a write: the output enable drops with no turnaround cycles, or the bus is driven from both sides at once. A wrong lane mask gives either a corrupted neighbour byte, seen on the next read back, or a stray 0xEE pattern in a masked read. A faulty recovery counter changes the measured count of cycles in which `req_ready` stays low after retention.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W      = 17,
  parameter int LANES       = 4,
  parameter int LANE_W      = 8,
  parameter int RD_CYCLES   = 2,
  parameter int WE_CYCLES   = 2,
  parameter int TURN_CYCLES = 1,
  parameter int REC_CYCLES  = 1000000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANES-1:0]        req_be,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  input  logic                    ret_req,
  output logic [ADDR_W-1:0]       sram_addr,
  output logic [LANES-1:0]        sram_cs_n,
  output logic [LANES-1:0]        sram_we_n,
  output logic                    sram_oe_n,
  output logic [LANES*LANE_W-1:0] sram_dq_out,
  output logic                    sram_dq_oe,
  input  logic [LANES*LANE_W-1:0] sram_dq_in
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int CNT_W  = $clog2(REC_CYCLES + RD_CYCLES + WE_CYCLES + TURN_CYCLES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_TURN, S_READ, S_WSET, S_WSTB, S_WHOLD, S_RET, S_REC
  } state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]    be_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                last_wr;
  logic [DATA_W-1:0]   rdata_q;
  logic                rvalid_q;
  logic [DATA_W-1:0]   rd_masked;
  logic                cnt_done;
  logic                lanes_on;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_masked[g*LANE_W +: LANE_W] = be_q[g] ? sram_dq_in[g*LANE_W +: LANE_W] : '0;
  end

  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      last_wr  <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            if (req_we) begin
              state <= S_WSET;
            end else if (last_wr) begin
              state <= S_TURN;
              cnt   <= CNT_W'(TURN_CYCLES - 1);
            end else begin
              state <= S_READ;
              cnt   <= CNT_W'(RD_CYCLES - 1);
            end
          end else if (ret_req) begin
            state <= S_RET;
          end
        end
        S_TURN: begin
          if (cnt_done) begin
            state <= S_READ;
            cnt   <= CNT_W'(RD_CYCLES - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_READ: begin
          if (cnt_done) begin
            state    <= S_IDLE;
            rdata_q  <= rd_masked;
            rvalid_q <= 1'b1;
            last_wr  <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WSET: begin
          state <= S_WSTB;
          cnt   <= CNT_W'(WE_CYCLES - 1);
        end
        S_WSTB: begin
          if (cnt_done) state <= S_WHOLD;
          else          cnt   <= cnt - 1'b1;
        end
        S_WHOLD: begin
          state   <= S_IDLE;
          last_wr <= 1'b1;
        end
        S_RET: begin
          if (!ret_req) begin
            state <= S_REC;
            cnt   <= CNT_W'(REC_CYCLES - 1);
          end
        end
        S_REC: begin
          if (cnt_done) state <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign lanes_on    = (state == S_READ) || (state == S_WSET) ||
                       (state == S_WSTB) || (state == S_WHOLD);
  assign sram_cs_n   = lanes_on ? ~be_q : '1;
  assign sram_we_n   = (state == S_WSTB) ? ~be_q : '1;
  assign sram_oe_n   = (state != S_READ);
  assign sram_dq_oe  = (state == S_WSET) || (state == S_WSTB) || (state == S_WHOLD);
  assign sram_dq_out = wdata_q;
  assign sram_addr   = addr_q;
  assign req_ready   = (state == S_IDLE);
  assign rsp_valid   = rvalid_q;
  assign rsp_rdata   = rdata_q;

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_dq_oe && !sram_oe_n));

  // R11
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sram_we_n) & sram_cs_n) == '0);

  // R2
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&sram_we_n) && $past(!(&sram_we_n))) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&sram_cs_n && sram_oe_n && !sram_dq_oe));

  // R2
  strobe_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sram_we_n) |-> (sram_dq_oe && sram_oe_n));
endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int RD   = 2;
  localparam int WEC  = 3;
  localparam int TURN = 2;
  localparam int REC  = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, req_we, ret_req;
  logic [16:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_valid, sram_oe_n, sram_dq_oe;
  logic [31:0] rsp_rdata, sram_dq_out, sram_dq_in;
  logic [16:0] sram_addr;
  logic [3:0]  sram_cs_n, sram_we_n;

  sram_ctl #(.RD_CYCLES(RD), .WE_CYCLES(WEC), .TURN_CYCLES(TURN), .REC_CYCLES(REC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  logic [31:0] model [0:255];
  logic [31:0] refm  [0:255];
  int total = 0;
  int bad = 0;
  bit prev_wr = 0;

  always_comb begin
    for (int l = 0; l < 4; l++)
      sram_dq_in[l*8 +: 8] = (!sram_cs_n[l] && !sram_oe_n && sram_we_n[l])
                             ? model[sram_addr[7:0]][l*8 +: 8] : 8'hEE;
  end

  always @(posedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!sram_we_n[l] && !sram_cs_n[l])
        model[sram_addr[7:0]][l*8 +: 8] <= sram_dq_out[l*8 +: 8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n === 1'b1 && sram_dq_oe && !sram_oe_n)
      check(1'b0, "R7 bus contention", {31'd0, sram_dq_oe}, 32'd0);

  task automatic do_write(input logic [16:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    check(req_ready === 1'b1, "R8 ready before write", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_we = 1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check(sram_cs_n == ~be && sram_we_n == 4'hF && sram_oe_n && sram_dq_oe,
          "R2 setup cycle", {24'd0, sram_cs_n, sram_we_n}, {24'd0, ~be, 4'hF});
    check(req_ready == 1'b0, "R8 busy in write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    for (int k = 0; k < WEC; k++) begin
      check(sram_we_n == ~be && sram_cs_n == ~be && sram_oe_n && sram_dq_oe,
            "R2 R3 strobe", {24'd0, sram_cs_n, sram_we_n}, {24'd0, ~be, ~be});
      check(sram_dq_out == d && sram_addr == a, "R2 strobe data", sram_dq_out, d);
      @(negedge clk);
    end
    check(sram_we_n == 4'hF && sram_cs_n == ~be && sram_dq_oe,
          "R2 hold cycle", {24'd0, sram_cs_n, sram_we_n}, {24'd0, ~be, 4'hF});
    @(negedge clk);
    check(req_ready && &sram_cs_n && !sram_dq_oe, "R8 idle after write",
          {27'd0, req_ready, sram_cs_n}, {27'd0, 1'b1, 4'hF});
    for (int l = 0; l < 4; l++) if (be[l]) refm[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
    prev_wr = 1;
  endtask

  task automatic do_read(input logic [16:0] a, input logic [3:0] be);
    logic [31:0] exp;
    for (int l = 0; l < 4; l++) exp[l*8 +: 8] = be[l] ? refm[a[7:0]][l*8 +: 8] : 8'h00;
    @(negedge clk);
    check(req_ready === 1'b1, "R8 ready before read", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_we = 0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0;
    if (prev_wr) begin
      for (int k = 0; k < TURN; k++) begin
        check(&sram_cs_n && sram_oe_n && !sram_dq_oe, "R6 turnaround",
              {27'd0, sram_oe_n, sram_cs_n}, {27'd0, 1'b1, 4'hF});
        @(negedge clk);
      end
    end
    for (int k = 0; k < RD; k++) begin
      check(sram_cs_n == ~be && !sram_oe_n && sram_we_n == 4'hF && sram_addr == a,
            "R4 R5 R6 read strobe", {27'd0, sram_oe_n, sram_cs_n}, {27'd0, 1'b0, ~be});
      check(rsp_valid == 1'b0, "R4 early valid", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
    check(rsp_valid == 1'b1, "R4 valid pulse", {31'd0, rsp_valid}, 32'd1);
    check(rsp_rdata == exp, "R4 R5 read data", rsp_rdata, exp);
    check(req_ready && sram_oe_n, "R8 idle after read", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R4 single pulse", {31'd0, rsp_valid}, 32'd0);
    prev_wr = 0;
  endtask

  task automatic wait_recovery(input string tag);
    int n = 0;
    @(negedge clk);
    while (!req_ready && n < 1000) begin
      n++;
      if (!(&sram_cs_n)) check(1'b0, "R10 cs during recovery", {28'd0, sram_cs_n}, 32'hF);
      @(negedge clk);
    end
    check(n == REC, tag, n, REC);
  endtask

  task automatic test_retention();
    @(negedge clk);
    ret_req = 1;
    @(negedge clk);
    check(!req_ready && &sram_cs_n, "R9 retention entered", {27'd0, req_ready, sram_cs_n}, {27'd0, 1'b0, 4'hF});
    req_valid = 1; req_we = 1; req_addr = 17'd5; req_be = 4'hF; req_wdata = 32'hBAD0BAD0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!req_ready && &sram_cs_n && &sram_we_n && !sram_dq_oe, "R9 request ignored",
            {23'd0, req_ready, sram_cs_n, sram_we_n}, {23'd0, 1'b0, 4'hF, 4'hF});
    end
    req_valid = 0;
    ret_req = 0;
    wait_recovery("R10 recovery length");
    do_read(17'd5, 4'hF);
  endtask

  task automatic test_collision();
    @(negedge clk);
    ret_req = 1;
    req_valid = 1; req_we = 1; req_addr = 17'd7; req_be = 4'hF; req_wdata = 32'h0BADF00D;
    @(negedge clk);
    req_valid = 0;
    check(sram_cs_n == 4'h0 && sram_dq_oe, "R9 access before retention", {28'd0, sram_cs_n}, 32'd0);
    repeat (WEC + 2) @(negedge clk);
    check(req_ready == 1'b1, "R9 idle between", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    check(!req_ready && &sram_cs_n, "R9 retention after access", {31'd0, req_ready}, 32'd0);
    refm[7] = 32'h0BADF00D;
    prev_wr = 1;
    ret_req = 0;
    wait_recovery("R10 recovery after collision");
    do_read(17'd7, 4'hF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin model[i] = 32'd0; refm[i] = 32'd0; end
    rst_n = 0; req_valid = 0; req_we = 0; ret_req = 0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(req_ready && &sram_cs_n && &sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid,
          "R1 reset state", {22'd0, req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe},
          {22'd0, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0});
    rst_n = 1;
    @(negedge clk);
    check(req_ready && &sram_cs_n && !rsp_valid, "R1 first idle", {31'd0, req_ready}, 32'd1);

    do_write(17'h00010, 4'hF, 32'h11223344);
    do_read (17'h00010, 4'hF);
    do_read (17'h00010, 4'hF);
    do_write(17'h00010, 4'b0101, 32'hAABBCCDD);
    do_read (17'h00010, 4'hF);
    do_read (17'h00010, 4'b1010);
    do_write(17'h1FF20, 4'hF, 32'hCAFEBABE);
    do_write(17'h00021, 4'b1000, 32'h5A000000);
    do_read (17'h1FF20, 4'b0011);
    do_read (17'h00021, 4'hF);
    do_write(17'h00005, 4'hF, 32'h01020304);
    test_retention();
    test_collision();
    do_write(17'h00033, 4'b0110, 32'hFFFFFFFF);
    do_read (17'h00033, 4'b0100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule